// File: doc/BRIEF.md
# Interrupt Status Latch and Summary

This block is the event status register of a network DMA controller. Single-cycle event pulses from the transmit engine, the receive engine, two timers and the bus interface are captured into sticky status bits. Software clears a bit by writing a one to its position. Two summary bits collect the pending events into a "normal" group and an "abnormal" group. Three read-only fields report the transmit process state, the receive process state and the type of the last fatal bus error.

A separate 32-bit enable register selects which status bits may request an interrupt. The active-low request output is low while any enabled status bit is pending. A fatal bus error also raises a bus-access hold output. Clearing the status bit does not release that hold; only a software reset pulse does. The register port is a plain write strobe, a one-bit register select and a combinational read data bus.

Top module: `irq_status_unit`

## Requirements
- R1: A latched event bit becomes 1 on the clock edge that samples its event pulse. It stays 1 until a write to the status register (`reg_sel`=0) carries a 1 in that bit position. Writing 0 to a set bit leaves it set.
- R2: Event input index maps to status bit as follows: 0 transmit done→bit 0, 1 transmit stopped→bit 1, 2 transmit descriptor missing→bit 2, 3 transmit jabber→bit 3, 4 transmit underflow→bit 5, 5 receive done→bit 6, 6 receive descriptor missing→bit 7, 7 receive stopped→bit 8, 8 receive watchdog→bit 9, 9 general timer→bit 11, 10 fatal bus error→bit 13.
- R3: If an event pulse and a write-one clear of the same bit arrive in the same cycle, the bit remains set.
- R4: Status bit 15 reads 1 exactly when at least one of bits 1, 3, 5, 7, 8, 9, 11, 13 is set.
- R5: Status bit 16 reads 1 exactly when at least one of bits 0, 2, 6 is set.
- R6: A transmit-done pulse sets bit 0 only when `tx_req_irq` is 1 in the same cycle; otherwise bit 0 stays unchanged.
- R7: Status bits 22:20 show `tx_state` and bits 19:17 show `rx_state` combinationally. Writes do not alter them.
- R8: When a fatal bus error pulse arrives while bit 13 is clear, `bus_err_code` is captured. Bits 25:23 show that captured code while bit 13 is set and read 000 while it is clear. Later fatal pulses do not replace the code while bit 13 stays set.
- R9: `dma_hold` rises on the edge after a fatal bus error pulse and stays high until `soft_rst` is sampled high. A write-one clear of bit 13 does not drop it.
- R10: `irq_n` is 0 exactly when some bit among 0 to 13, 15 and 16 is set in both the status word and the enable register. The state fields and the error type field never drive it.
- R11: The enable register (`reg_sel`=1) stores all 32 written bits and reads them back. Status bits 4, 10, 12, 14 and 31:26 always read 0.
- R12: After reset the status event bits and the enable register are 0, `irq_n` is 1 and `dma_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 11 | One-cycle event pulses, index order as in R2 |
| tx_req_irq | input | 1 | Completed frame's first descriptor asked for an interrupt |
| tx_state | input | 3 | Transmit process state code |
| rx_state | input | 3 | Receive process state code |
| bus_err_code | input | 3 | Bus error type (000 parity, 001 master abort, 010 target abort) |
| soft_rst | input | 1 | Software reset pulse, releases the bus-access hold |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |
| dma_hold | output | 1 | Bus-access disable after a fatal bus error |

## Verification
Event pulses and register writes land on the next rising edge. The status word, the summaries and `irq_n` follow combinationally from those registers, so each of these results is due one cycle after its stimulus. The state fields and the read select act within the same cycle. The bench drives every input one time unit after a rising edge and reads outputs one time unit after the following edge. Each expectation is therefore compared exactly one register stage after the stimulus, or in the same cycle for purely combinational paths. Sticky behaviour is checked by reading back after zero-writes and after unrelated clears, before any further stimulus.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_EVT   = 11;
    localparam int EVT_SPAN  = 15;
    localparam int ST_W      = 3;

    localparam int POS_FATAL = 13;
    localparam int POS_ABN   = 15;
    localparam int POS_NRM   = 16;

    localparam logic [REG_W-1:0] ABN_MASK = 32'h0000_2BAA;
    localparam logic [REG_W-1:0] NRM_MASK = 32'h0000_0045;
    localparam logic [REG_W-1:0] IRQ_MASK = ABN_MASK | NRM_MASK
                                          | (32'h1 << POS_ABN) | (32'h1 << POS_NRM);

    typedef enum int {
        EV_TX_DONE   = 0,
        EV_TX_STOP   = 1,
        EV_TX_NODESC = 2,
        EV_TX_JABBER = 3,
        EV_TX_UFLOW  = 4,
        EV_RX_DONE   = 5,
        EV_RX_NODESC = 6,
        EV_RX_STOP   = 7,
        EV_RX_WDOG   = 8,
        EV_GP_TIMER  = 9,
        EV_BUS_FATAL = 10
    } evt_idx_e;

    typedef struct packed {
        logic [5:0]          rsv;
        logic [ST_W-1:0]     err_type;
        logic [ST_W-1:0]     tx_st;
        logic [ST_W-1:0]     rx_st;
        logic                nrm;
        logic                abn;
        logic [EVT_SPAN-1:0] evts;
    } stat_word_t;

    function automatic int evt_pos(input int idx);
        case (idx)
            0:  return 0;
            1:  return 1;
            2:  return 2;
            3:  return 3;
            4:  return 5;
            5:  return 6;
            6:  return 7;
            7:  return 8;
            8:  return 9;
            9:  return 11;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/isr_evt_bit.sv
module isr_evt_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);                                   // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);                         // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!q_o && !set_i) |=> !q_o);                       // R1

endmodule

// File: rtl/isr_summary.sv
module isr_summary
    import isr_pkg::*;
(
    input  logic [EVT_SPAN-1:0] evts_i,
    input  logic [ST_W-1:0]     tx_st_i,
    input  logic [ST_W-1:0]     rx_st_i,
    input  logic                err_valid_i,
    input  logic [ST_W-1:0]     err_code_i,
    input  logic [REG_W-1:0]    enable_i,
    output logic [REG_W-1:0]    word_o,
    output logic                irq_n_o
);

    stat_word_t               sw;
    logic [REG_W-1:0]         ev_wide;

    always_comb begin
        ev_wide     = {{(REG_W-EVT_SPAN){1'b0}}, evts_i};
        sw          = '0;
        sw.evts     = evts_i;
        sw.abn      = |(ev_wide & ABN_MASK);
        sw.nrm      = |(ev_wide & NRM_MASK);
        sw.tx_st    = tx_st_i;
        sw.rx_st    = rx_st_i;
        sw.err_type = err_valid_i ? err_code_i : '0;
        word_o      = sw;
        irq_n_o     = ~|(word_o & enable_i & IRQ_MASK);
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic                 tx_req_irq,
    input  logic [ST_W-1:0]      tx_state,
    input  logic [ST_W-1:0]      rx_state,
    input  logic [ST_W-1:0]      bus_err_code,
    input  logic                 soft_rst,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq_n,
    output logic                 dma_hold
);

    logic [NUM_EVT-1:0]  evt_q;
    logic [NUM_EVT-1:0]  evt_set;
    logic [NUM_EVT-1:0]  evt_clr;
    logic [EVT_SPAN-1:0] evts;
    logic [REG_W-1:0]    enable_q;
    logic [REG_W-1:0]    status_w;
    logic [ST_W-1:0]     err_q;
    logic                wr_status;
    logic                fatal_q;

    assign wr_status = reg_wr && !reg_sel;

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        localparam int POS = evt_pos(gi);
        if (gi == EV_TX_DONE) begin : g_gated
            assign evt_set[gi] = evt_pulse[gi] && tx_req_irq;
        end else begin : g_plain
            assign evt_set[gi] = evt_pulse[gi];
        end
        assign evt_clr[gi] = wr_status && reg_wdata[POS];

        isr_evt_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_set[gi]),
            .clr_i (evt_clr[gi]),
            .q_o   (evt_q[gi])
        );
    end

    always_comb begin
        evts = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            evts[evt_pos(i)] = evt_q[i];
        end
    end

    assign fatal_q = evt_q[EV_BUS_FATAL];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            err_q    <= '0;
            dma_hold <= 1'b0;
        end else begin
            if (reg_wr && reg_sel)
                enable_q <= reg_wdata;
            if (evt_pulse[EV_BUS_FATAL] && !fatal_q)
                err_q <= bus_err_code;
            if (soft_rst)
                dma_hold <= 1'b0;
            else if (evt_pulse[EV_BUS_FATAL])
                dma_hold <= 1'b1;
        end
    end

    isr_summary u_sum (
        .evts_i      (evts),
        .tx_st_i     (tx_state),
        .rx_st_i     (rx_state),
        .err_valid_i (fatal_q),
        .err_code_i  (err_q),
        .enable_i    (enable_q),
        .word_o      (status_w),
        .irq_n_o     (irq_n)
    );

    assign reg_rdata = reg_sel ? enable_q : status_w;

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (dma_hold && !soft_rst) |=> dma_hold);                          // R9
    AST_FATAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[EV_BUS_FATAL] && !soft_rst) |=> dma_hold);            // R9
    AST_ERR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fatal_q && $past(fatal_q)) |-> $stable(err_q));                 // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((enable_q & IRQ_MASK) == '0) |-> irq_n);                        // R10

endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] evt_pulse;
    logic        tx_req_irq;
    logic [2:0]  tx_state;
    logic [2:0]  rx_state;
    logic [2:0]  bus_err_code;
    logic        soft_rst;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_n;
    logic        dma_hold;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .tx_req_irq(tx_req_irq),
        .tx_state(tx_state), .rx_state(rx_state), .bus_err_code(bus_err_code),
        .soft_rst(soft_rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
        .dma_hold(dma_hold)
    );

    localparam logic [31:0] ABN = 32'h0000_2BAA;
    localparam logic [31:0] NRM = 32'h0000_0045;

    function automatic int pos_of(input int idx);
        int tbl [11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
        return tbl[idx];
    endfunction

    function automatic logic [31:0] word(input logic [31:0] ev, input logic [2:0] tx,
                                         input logic [2:0] rx, input logic [2:0] er);
        logic [31:0] w;
        w = ev;
        if ((ev & ABN) != 0) w[15] = 1'b1;
        if ((ev & NRM) != 0) w[16] = 1'b1;
        w[22:20] = tx;
        w[19:17] = rx;
        w[25:23] = ev[13] ? er : 3'b000;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
        evt_pulse = '0; reg_wr = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic rd_status(output logic [31:0] v);
        reg_sel = 1'b0; #1; v = reg_rdata;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_status(v);
        chk("R12 status", v, 32'h0);
        reg_sel = 1'b1; #1;
        chk("R12 enable", reg_rdata, 32'h0);
        chk("R12 irq_n", {31'b0, irq_n}, 32'h1);
        chk("R12 dma_hold", {31'b0, dma_hold}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        logic [31:0] ev;
        tx_req_irq = 1'b1;
        for (int i = 0; i < 10; i++) begin
            evt_pulse[i] = 1'b1;
            step();
            ev = 32'h1 << pos_of(i);
            rd_status(v);
            chk("R2 R4 R5 position and summaries", v, word(ev, 3'd0, 3'd0, 3'd0));
            wr_reg(1'b0, ev);
            rd_status(v);
            chk("R1 write-one clears", v, 32'h0);
        end
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        evt_pulse[5] = 1'b1;
        step();
        wr_reg(1'b0, 32'h0);
        rd_status(v);
        chk("R1 zero write keeps bit 6", v, word(32'h40, 3'd0, 3'd0, 3'd0));
        wr_reg(1'b0, 32'hFFFF_FFBF);
        rd_status(v);
        chk("R1 other ones keep bit 6", v, word(32'h40, 3'd0, 3'd0, 3'd0));
        wr_reg(1'b0, 32'h40);
        rd_status(v);
        chk("R1 bit 6 cleared", v, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        evt_pulse[6] = 1'b1;
        step();
        evt_pulse[6] = 1'b1;
        wr_reg(1'b0, 32'h80);
        rd_status(v);
        chk("R3 set beats clear", v, word(32'h80, 3'd0, 3'd0, 3'd0));
        wr_reg(1'b0, 32'h80);
        rd_status(v);
        chk("R3 later clear works", v, 32'h0);
    endtask

    task automatic t_txgate;
        logic [31:0] v;
        tx_req_irq = 1'b0;
        evt_pulse[0] = 1'b1;
        step();
        rd_status(v);
        chk("R6 ungated done ignored", v, 32'h0);
        tx_req_irq = 1'b1;
        evt_pulse[0] = 1'b1;
        step();
        rd_status(v);
        chk("R6 requested done latched", v, word(32'h1, 3'd0, 3'd0, 3'd0));
        wr_reg(1'b0, 32'h1);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        tx_state = 3'd5; rx_state = 3'd3;
        rd_status(v);
        chk("R7 state fields", v, word(32'h0, 3'd5, 3'd3, 3'd0));
        wr_reg(1'b1, 32'hFFFF_FFFF);
        chk("R10 fields raise no irq", {31'b0, irq_n}, 32'h1);
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_status(v);
        chk("R7 R11 writes ignored, reserved zero", v, word(32'h0, 3'd5, 3'd3, 3'd0));
        wr_reg(1'b1, 32'h0);
        tx_state = 3'd0; rx_state = 3'd0;
    endtask

    task automatic t_err;
        logic [31:0] v;
        bus_err_code = 3'd2;
        evt_pulse[10] = 1'b1;
        step();
        rd_status(v);
        chk("R8 code captured", v, word(32'h2000, 3'd0, 3'd0, 3'd2));
        chk("R9 hold set", {31'b0, dma_hold}, 32'h1);
        bus_err_code = 3'd1;
        evt_pulse[10] = 1'b1;
        step();
        rd_status(v);
        chk("R8 code kept", v, word(32'h2000, 3'd0, 3'd0, 3'd2));
        wr_reg(1'b0, 32'h2000);
        rd_status(v);
        chk("R8 field zero when clear", v, 32'h0);
        chk("R9 hold survives clear", {31'b0, dma_hold}, 32'h1);
        soft_rst = 1'b1;
        step();
        chk("R9 soft reset releases", {31'b0, dma_hold}, 32'h0);
        evt_pulse[10] = 1'b1;
        step();
        rd_status(v);
        chk("R8 new code after clear", v, word(32'h2000, 3'd0, 3'd0, 3'd1));
        wr_reg(1'b0, 32'h2000);
        soft_rst = 1'b1;
        step();
    endtask

    task automatic t_irq;
        wr_reg(1'b1, 32'h0001_0000);
        reg_sel = 1'b1; #1;
        chk("R11 enable readback", reg_rdata, 32'h0001_0000);
        chk("R10 nothing pending", {31'b0, irq_n}, 32'h1);
        evt_pulse[5] = 1'b1;
        step();
        chk("R10 normal summary irq", {31'b0, irq_n}, 32'h0);
        wr_reg(1'b1, 32'h0000_8000);
        chk("R10 abnormal enable only", {31'b0, irq_n}, 32'h1);
        wr_reg(1'b1, 32'h0000_0040);
        chk("R10 direct bit irq", {31'b0, irq_n}, 32'h0);
        wr_reg(1'b0, 32'h40);
        chk("R10 cleared releases irq", {31'b0, irq_n}, 32'h1);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; evt_pulse = '0; tx_req_irq = 1'b0; tx_state = '0; rx_state = '0;
        bus_err_code = '0; soft_rst = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_map();
        t_w1c();
        t_collide();
        t_txgate();
        t_fields();
        t_err();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule